// File: doc/BRIEF.md
# Per-Pixel Offset Correction Unit

This block takes a stream of 10-bit pixels from an image sensor and removes the fixed pattern noise: the static offset that differs from pixel to pixel. The offsets live in an external synchronous memory. That memory holds several offset frames, one for each timing and illumination condition. A slot select input picks the frame. The memory address is the slot number, placed above the pixel address.

In calibration mode, the camera views a uniform grey target. Each valid raw pixel of that frame is written into the selected slot at its own pixel address. Nothing is emitted on the output during calibration. In correction mode, the block reads the offset stored at the same pixel position and subtracts it from the raw sample. The difference is computed with a signed intermediate and clipped to the 0..1023 range. A pipeline matches the memory read latency, so every sample leaves a fixed number of cycles after it arrives, with no frame of delay. A bypass control sends raw pixels through unchanged, with the same latency and without a memory read.

The mode, bypass and slot inputs are taken with each sample. They may change on any cycle.

Top module: `pixel_offset_corrector`

## Requirements
- R1: While reset is asserted and after it is released with no input, outValid, memWe and memRe are all 0.
- R2: When calibration is on and inValid is 1, memWe is 1 in the same cycle and memWdata equals the raw pixel. memRe stays 0, and the sample never produces outValid. A later calibration of the same slot overwrites the earlier offsets.
- R3: In correction mode with bypass off, a sample whose raw value is at least its stored offset comes out as raw minus offset. Equal values give 0.
- R4: In correction mode with bypass off, a sample whose raw value is below its stored offset comes out as 0.
- R5: On any memory access, memAddr is slotSel in the upper SLOT_W bits and inAddr in the lower ADDR_W bits. The offset that is subtracted comes from the slot selected with that sample.
- R6: A sample presented with inValid in cycle c and calibration off shows outValid in cycle c+RD_LAT+1, for exactly one cycle per sample.
- R7: With bypass on and calibration off, a valid sample comes out unchanged with the same latency, and memRe stays 0.
- R8: In a cycle with inValid at 0, memWe and memRe are 0 and no output sample results.
- R9: Calibration, bypass and slot select are taken with each sample. Changing them between back-to-back samples affects only the samples that come later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeCal | input | 1 | 1 = calibration (store raw frame), 0 = correction |
| bypass | input | 1 | 1 = pass raw pixels unchanged when not calibrating |
| slotSel | input | SLOT_W | Offset frame slot for this sample |
| inValid | input | 1 | Input sample valid |
| inAddr | input | ADDR_W | Pixel address of the sample within a frame |
| inPix | input | PIX_W | Raw pixel value |
| memWe | output | 1 | Offset memory write strobe |
| memRe | output | 1 | Offset memory read strobe |
| memAddr | output | SLOT_W+ADDR_W | Offset memory address {slot, pixel} |
| memWdata | output | PIX_W | Offset memory write data |
| memRdata | input | PIX_W | Offset memory read data, RD_LAT cycles after memRe |
| outValid | output | 1 | Output sample valid |
| outPix | output | PIX_W | Corrected or bypassed pixel |

## Verification
Four offset frames are captured with different shapes: a scattered mid-range pattern, all zeros, all full-scale, and a ramp. Raw ramps are then corrected against each frame. Against the zero frame, the raw value must come back exactly, including 1023. Against the full-scale frame, every result must clip to 0. Against the scattered frame, the outputs mix plain differences, differences that come out exactly 0, and clipped negatives. Changing the slot, bypass and calibration on back-to-back samples, and inserting gaps in the valid stream, shows whether the per-sample controls stay aligned with the data through the latency pipeline. A second calibration of one slot shows whether new offsets replace old ones.

// File: rtl/poc_pkg.sv
package poc_pkg;
  // Strobes the control stage hands to the datapath with each accepted sample.
  typedef struct packed {
    logic emit;   // sample will appear on the output
    logic rdEn;   // sample is corrected with a stored offset (not bypassed)
  } strobeT;
endpackage

// File: rtl/poc_ctrl.sv
module poc_ctrl
  import poc_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int ADDR_W = 20,
  parameter int SLOT_W = 2
) (
  input  logic                     modeCal,
  input  logic                     bypass,
  input  logic [SLOT_W-1:0]        slotSel,
  input  logic                     inValid,
  input  logic [ADDR_W-1:0]        inAddr,
  input  logic [PIX_W-1:0]         inPix,
  output strobeT                   st,
  output logic                     memWe,
  output logic                     memRe,
  output logic [SLOT_W+ADDR_W-1:0] memAddr,
  output logic [PIX_W-1:0]         memWdata
);
  logic calHit;
  logic corHit;

  always_comb begin
    calHit   = inValid && modeCal;
    corHit   = inValid && !modeCal;
    memWe    = calHit;
    memRe    = corHit && !bypass;
    memAddr  = {slotSel, inAddr};
    memWdata = inPix;
    st.emit  = corHit;
    st.rdEn  = corHit && !bypass;
  end
endmodule

// File: rtl/poc_datapath.sv
module poc_datapath
  import poc_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int RD_LAT = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           st,
  input  logic [PIX_W-1:0] inPix,
  input  logic [PIX_W-1:0] memRdata,
  output logic             outValid,
  output logic [PIX_W-1:0] outPix
);
  localparam int DW = PIX_W + 2;
  localparam logic signed [DW-1:0] MAXV = DW'((1 << PIX_W) - 1);

  logic [PIX_W-1:0] rawPipe  [RD_LAT];
  logic             emitPipe [RD_LAT];
  logic             rdPipe   [RD_LAT];

  for (genvar s = 0; s < RD_LAT; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          emitPipe[0] <= 1'b0;
          rdPipe[0]   <= 1'b0;
          rawPipe[0]  <= '0;
        end else begin
          emitPipe[0] <= st.emit;
          rdPipe[0]   <= st.rdEn;
          rawPipe[0]  <= inPix;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          emitPipe[s] <= 1'b0;
          rdPipe[s]   <= 1'b0;
          rawPipe[s]  <= '0;
        end else begin
          emitPipe[s] <= emitPipe[s-1];
          rdPipe[s]   <= rdPipe[s-1];
          rawPipe[s]  <= rawPipe[s-1];
        end
      end
    end
  end

  function automatic logic [PIX_W-1:0] clipDiff(input logic [PIX_W-1:0] raw,
                                                input logic [PIX_W-1:0] off);
    logic signed [DW-1:0] diff;
    diff = $signed({2'b00, raw}) - $signed({2'b00, off});
    if (diff < 0)         return '0;
    else if (diff > MAXV) return MAXV[PIX_W-1:0];
    else                  return diff[PIX_W-1:0];
  endfunction

  logic [PIX_W-1:0] tailRaw;
  logic [PIX_W-1:0] nextPix;

  always_comb begin
    tailRaw = rawPipe[RD_LAT-1];
    nextPix = rdPipe[RD_LAT-1] ? clipDiff(tailRaw, memRdata) : tailRaw;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outPix   <= '0;
    end else begin
      outValid <= emitPipe[RD_LAT-1];
      if (emitPipe[RD_LAT-1]) outPix <= nextPix;
    end
  end
endmodule

// File: rtl/pixel_offset_corrector.sv
module pixel_offset_corrector
  import poc_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int ADDR_W = 20,
  parameter int SLOTS  = 4,
  parameter int RD_LAT = 1,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     modeCal,
  input  logic                     bypass,
  input  logic [SLOT_W-1:0]        slotSel,
  input  logic                     inValid,
  input  logic [ADDR_W-1:0]        inAddr,
  input  logic [PIX_W-1:0]         inPix,
  output logic                     memWe,
  output logic                     memRe,
  output logic [SLOT_W+ADDR_W-1:0] memAddr,
  output logic [PIX_W-1:0]         memWdata,
  input  logic [PIX_W-1:0]         memRdata,
  output logic                     outValid,
  output logic [PIX_W-1:0]         outPix
);
  strobeT st;

  poc_ctrl #(.PIX_W(PIX_W), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_ctrl (
    .modeCal(modeCal), .bypass(bypass), .slotSel(slotSel), .inValid(inValid),
    .inAddr(inAddr), .inPix(inPix), .st(st), .memWe(memWe), .memRe(memRe),
    .memAddr(memAddr), .memWdata(memWdata)
  );

  poc_datapath #(.PIX_W(PIX_W), .RD_LAT(RD_LAT)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .inPix(inPix), .memRdata(memRdata),
    .outValid(outValid), .outPix(outPix)
  );
endmodule

// File: rtl/poc_checker.sv
module poc_checker #(
  parameter int PIX_W  = 10,
  parameter int ADDR_W = 20,
  parameter int SLOT_W = 2,
  parameter int RD_LAT = 1
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     modeCal,
  input logic                     bypass,
  input logic [SLOT_W-1:0]        slotSel,
  input logic                     inValid,
  input logic [ADDR_W-1:0]        inAddr,
  input logic [PIX_W-1:0]         inPix,
  input logic                     memWe,
  input logic                     memRe,
  input logic [SLOT_W+ADDR_W-1:0] memAddr,
  input logic [PIX_W-1:0]         memWdata,
  input logic                     outValid,
  input logic [PIX_W-1:0]         outPix
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd0) |-> (!outValid));

  assert_cal_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeCal) |-> (memWe && !memRe && memWdata == inPix));

  assert_slot_addr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memWe || memRe) |-> (memAddr[SLOT_W+ADDR_W-1 -: SLOT_W] == slotSel
                          && memAddr[ADDR_W-1:0] == inAddr));

  assert_bypass_noread_R7: assert property (@(posedge clk) disable iff (!rstN)
    bypass |-> !memRe);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> (!memWe && !memRe));

  if (RD_LAT == 1) begin : g_lat1
    assert_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
      (age == 2'd3) |-> (outValid == $past(inValid && !modeCal, 2)));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
      (age == 2'd3 && outValid) |-> (outPix <= $past(inPix, 2)));

    assert_bypass_same_R7: assert property (@(posedge clk) disable iff (!rstN)
      (age == 2'd3 && outValid && $past(bypass, 2)) |-> (outPix == $past(inPix, 2)));
  end
endmodule

bind pixel_offset_corrector poc_checker #(
  .PIX_W(PIX_W), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .RD_LAT(RD_LAT)
) u_chk (
  .clk(clk), .rstN(rstN), .modeCal(modeCal), .bypass(bypass), .slotSel(slotSel),
  .inValid(inValid), .inAddr(inAddr), .inPix(inPix), .memWe(memWe), .memRe(memRe),
  .memAddr(memAddr), .memWdata(memWdata), .outValid(outValid), .outPix(outPix)
);

// File: tb/tb_pixel_offset_corrector.sv
module tb_pixel_offset_corrector;
  localparam int PW = 10;
  localparam int AW = 4;
  localparam int NS = 4;
  localparam int SW = 2;
  localparam int NPIX = 1 << AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, modeCal, bypass, inValid;
  logic [SW-1:0] slotSel;
  logic [AW-1:0] inAddr;
  logic [PW-1:0] inPix;
  logic memWe, memRe, outValid;
  logic [SW+AW-1:0] memAddr;
  logic [PW-1:0] memWdata, outPix;
  logic [PW-1:0] memRdata = '0;

  pixel_offset_corrector #(.PIX_W(PW), .ADDR_W(AW), .SLOTS(NS), .RD_LAT(1)) dut (
    .clk(clk), .rstN(rstN), .modeCal(modeCal), .bypass(bypass), .slotSel(slotSel),
    .inValid(inValid), .inAddr(inAddr), .inPix(inPix), .memWe(memWe), .memRe(memRe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .outValid(outValid), .outPix(outPix)
  );

  // External offset memory stub, read latency 1.
  logic [PW-1:0] memArr [NS*NPIX];
  always @(posedge clk) begin
    if (memWe) memArr[memAddr] <= memWdata;
    if (memRe) memRdata <= memArr[memAddr];
  end

  // Reference model.
  int refOff [NS][NPIX];
  typedef struct { bit v; int pix; string tag; } expT;
  expT e0, e1;
  int total = 0;
  int bad = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      e0 = '{0, 0, "R1"};
      e1 = '{0, 0, "R1"};
    end else begin
      e1 = e0;
      if (inValid && modeCal) begin
        refOff[slotSel][inAddr] = int'(inPix);
        e0 = '{0, 0, "R2"};
      end else if (inValid && bypass) begin
        e0 = '{1, int'(inPix), "R7"};
      end else if (inValid) begin
        int d;
        d = int'(inPix) - refOff[slotSel][inAddr];
        if (d < 0) e0 = '{1, 0, "R4"};
        else       e0 = '{1, d, "R3"};
      end else begin
        e0 = '{0, 0, "R8"};
      end
    end
  end

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compareOut();
    check("R6", outValid === e1.v, int'(outValid), int'(e1.v));
    if (e1.v) check(e1.tag, outPix === PW'(e1.pix), int'(outPix), e1.pix);
  endtask

  task automatic checkMem();
    bit expWe, expRe;
    expWe = inValid && modeCal;
    expRe = inValid && !modeCal && !bypass;
    check("R2", memWe === expWe, int'(memWe), int'(expWe));
    check("R8", memRe === expRe, int'(memRe), int'(expRe));
    if (expWe || expRe)
      check("R5", memAddr === {slotSel, inAddr}, int'(memAddr), int'({slotSel, inAddr}));
    if (expWe) check("R2", memWdata === inPix, int'(memWdata), int'(inPix));
  endtask

  task automatic step(input bit v, input bit cal, input bit byp, input int slot,
                      input int addr, input int pix);
    @(negedge clk);
    compareOut();
    inValid = v; modeCal = cal; bypass = byp;
    slotSel = SW'(slot); inAddr = AW'(addr); inPix = PW'(pix);
    #1 checkMem();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    rstN = 0; modeCal = 0; bypass = 0; inValid = 0; slotSel = '0; inAddr = '0; inPix = '0;
    for (int s = 0; s < NS; s++) for (int a = 0; a < NPIX; a++) refOff[s][a] = 0;
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    check("R1", outValid === 1'b0, int'(outValid), 0);
    check("R1", memWe === 1'b0 && memRe === 1'b0, int'({memWe, memRe}), 0);
    rstN = 1;
    idle(3);
    check("R1", outValid === 1'b0, int'(outValid), 0);

    // R2: capture four differently shaped offset frames
    for (int a = 0; a < NPIX; a++) step(1, 1, 0, 0, a, (a * 37 + 80) % 400);
    for (int a = 0; a < NPIX; a++) step(1, 1, 0, 1, a, 0);
    for (int a = 0; a < NPIX; a++) step(1, 1, 0, 2, a, 1023);
    for (int a = 0; a < NPIX; a++) step(1, 1, 0, 3, a, a * 64 + 3);
    idle(2);

    // R3/R4: slot 0 with a descending ramp, plus exact-equal samples
    for (int a = 0; a < NPIX; a++) step(1, 0, 0, 0, a, 600 - a * 40);
    for (int a = 0; a < NPIX; a++) step(1, 0, 0, 0, a, (a * 37 + 80) % 400);
    // R3: zero offsets return raw, including full scale
    step(1, 0, 0, 1, 0, 1023);
    step(1, 0, 0, 1, 1, 0);
    for (int a = 0; a < NPIX; a++) step(1, 0, 0, 1, a, a * 67);
    // R4: full-scale offsets clip everything to zero
    for (int a = 0; a < NPIX; a++) step(1, 0, 0, 2, a, 1023 - a);
    // R8: gapped stream on slot 3
    for (int a = 0; a < NPIX; a++) begin
      step(1, 0, 0, 3, a, 1000 - a * 30);
      step(0, 0, 0, 3, a, 999);
    end
    // R5/R9: slot changes every sample
    for (int a = 0; a < NPIX; a++) step(1, 0, 0, a % NS, a, 512);
    // R7/R9: bypass alternates per sample
    for (int a = 0; a < NPIX; a++) step(1, 0, a % 2 == 1, 3, a, 700 + a);
    // R9: calibration interleaved with correction, then overwrite slot 0
    for (int a = 0; a < NPIX; a++) step(1, a % 2 == 0, 0, 0, a, 300 + a);
    for (int a = 0; a < NPIX; a++) step(1, 1, 0, 0, a, 5 * a);
    for (int a = 0; a < NPIX; a++) step(1, 0, 0, 0, a, 40 + a);
    idle(4);
    finishRun();
  end
endmodule